// File: doc/BRIEF.md
# DMA Linked-List Descriptor Loader

This block is the list-walking engine of a single DMA channel. It owns the channel's six working registers: two transfer-control words, the block-size word, the source and destination addresses and the link word. It also owns a 16-bit base register that gives the upper half of every descriptor address. Software fills these registers through a plain write port while the channel is idle. When the data mover signals that the current block is complete, the loader looks at the link word.

If the link word is zero, the channel reports completion and stops. Otherwise the loader joins the base register with the word-aligned offset held in the link word to form the next descriptor address. Six update flags in the link word select which registers to refresh. The selected words are read one at a time, from consecutive word addresses, in the fixed order transfer-control 1, transfer-control 2, block size, source, destination, link. Registers whose flag is clear keep their values. If the link word's own flag is clear, the link register is zeroed, so the freshly loaded block is the last one.

The loader then offers a restart to the data mover. A list whose last descriptor points back to its first keeps cycling without software help. The block also presents the number of transfers in the current block: the byte count divided by the destination data width.

Stream rules: the read request is a valid/ready channel. Once `rd_req_valid` is raised, it stays high and `rd_req_addr` stays unchanged until a cycle in which `rd_req_ready` is also high. The response side is accepted only while `rd_rsp_ready` is high, and `rd_rsp_ready` is high only after a request has been accepted. The restart offer follows the same rule: `restart_valid` holds until `restart_ready`.

Top module: `dma_ll_loader`

## Requirements
- R1: After reset, all six channel registers and the base register read zero, and `busy`, `done`, `error`, `rd_req_valid`, `rd_rsp_ready` and `restart_valid` are low.
- R2: Software write selector values 0 to 5 select transfer-control 1, transfer-control 2, block size, source, destination and link; selector 6 selects the base register (low 16 bits of the data). A write takes effect only while `busy` is low. A write made while `busy` is high changes nothing.
- R3: A `blk_done` pulse seen while idle with an all-zero link word raises `done` for exactly one cycle, starting the cycle after the pulse. No read is issued and `busy` stays low.
- R4: The first read of a load targets the address {base[15:0], link[15:2], 2'b00}.
- R5: Link bits 16 to 21 are the update flags for transfer-control 1, transfer-control 2, block size, source, destination and link, in that order. Only flagged registers are read. They are read in that order from consecutive word addresses that step by 4. Unflagged registers keep their values.
- R6: When link bit 21 is clear in the word that started the load, the link register reads zero once the load is complete.
- R7: At most one read is outstanding. `rd_req_valid` and `rd_rsp_ready` are never high together. A request held without `rd_req_ready` stays valid with a stable address.
- R8: A response with `rd_rsp_err` high pulses `error` for one cycle and returns the loader to idle without a restart. Registers not yet written keep their values.
- R9: After every flagged word has loaded, `restart_valid` rises and holds until `restart_ready`; then the loader is idle. `busy` is high from the cycle after the accepted `blk_done` until the restart handshake completes. A `blk_done` pulse while busy is ignored.
- R10: `blk_xfers` equals block-size bits [15:0] divided by the destination width in bytes. Transfer-control 1 bits [17:16] give that width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R11: A list whose last descriptor links back to the first keeps reloading in a cycle on successive `blk_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register selector (0-5 channel registers, 6 base) |
| sw_wdata | input | 32 | Software write data |
| blk_done | input | 1 | Data mover finished the current block |
| restart_valid | output | 1 | New block loaded, data mover may start |
| restart_ready | input | 1 | Data mover accepts the restart |
| rd_req_valid | output | 1 | Descriptor word read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Word address of the request |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_ready | output | 1 | Loader waits for a response |
| rd_rsp_data | input | 32 | Read response data |
| rd_rsp_err | input | 1 | Read response carries an error |
| ch_tr1 | output | 32 | Transfer-control 1 |
| ch_tr2 | output | 32 | Transfer-control 2 |
| ch_blk | output | 32 | Block size, bytes in bits [15:0] |
| ch_src | output | 32 | Source address |
| ch_dst | output | 32 | Destination address |
| ch_link | output | 32 | Link word |
| blk_xfers | output | 16 | Transfers in the current block |
| busy | output | 1 | Loader active |
| done | output | 1 | One-cycle end-of-list pulse |
| error | output | 1 | One-cycle read-error pulse |

## Verification
The bench builds the block with its default parameters: six registers, a 16-bit base and a 14-bit offset. That choice lets it place descriptors in two different 64 KiB windows and at offsets whose higher bits are set. A behavioural model that keeps the pending fetch list as a queue is compared with the block on every clock. Memory and data-mover readiness follow patterns that stall both handshakes, so held requests and delayed responses are exercised. The scenarios cover full and partial descriptor loads, an end-of-list load, an error on the second word of a load, and a two-descriptor cycle taken around three times.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
  // Register slot indices, also the fetch order from memory
  localparam int unsigned SLOT_TR1  = 0;
  localparam int unsigned SLOT_TR2  = 1;
  localparam int unsigned SLOT_BLK  = 2;
  localparam int unsigned SLOT_SRC  = 3;
  localparam int unsigned SLOT_DST  = 4;
  localparam int unsigned SLOT_LINK = 5;

  // Link word layout: offset field from bit 2, update flags from bit 16
  localparam int unsigned LINK_OFF_LSB  = 2;
  localparam int unsigned LINK_FLAG_LSB = 16;

  // Destination width code position in transfer-control 1
  localparam int unsigned DW_CODE_LSB = 16;
  localparam int unsigned BYTES_W     = 16;

  typedef enum logic [1:0] {
    LD_IDLE    = 2'd0,
    LD_REQ     = 2'd1,
    LD_WAIT    = 2'd2,
    LD_RESTART = 2'd3
  } ld_state_e;
endpackage

// File: rtl/dma_ll_regfile.sv
module dma_ll_regfile #(
  parameter int unsigned NREG = 6,
  parameter int unsigned DW   = 32,
  parameter int unsigned IW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_we,
  input  logic [IW-1:0]            sw_idx,
  input  logic [DW-1:0]            sw_data,
  input  logic                     ld_we,
  input  logic [IW-1:0]            ld_idx,
  input  logic [DW-1:0]            ld_data,
  input  logic                     clr_link,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  localparam int unsigned LINK_SLOT = NREG - 1;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [IW-1:0] MY_IDX = IW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
      end else if (ld_we && ld_idx == MY_IDX) begin
        regs_o[g] <= ld_data;
      end else if (clr_link && g == LINK_SLOT) begin
        regs_o[g] <= '0;
      end else if (sw_we && sw_idx == MY_IDX) begin
        regs_o[g] <= sw_data;
      end
    end
  end

  // R5
  keep_unflagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_we && !sw_we && !clr_link) |=> $stable(regs_o));
endmodule

// File: rtl/dma_ll_seq.sv
module dma_ll_seq
  import dma_ll_pkg::*;
#(
  parameter int unsigned NREG   = 6,
  parameter int unsigned DW     = 32,
  parameter int unsigned BASE_W = 16,
  parameter int unsigned OFF_W  = 14,
  parameter int unsigned IW     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        blk_done,
  input  logic [DW-1:0]               link_word,
  input  logic [BASE_W-1:0]           base,
  output logic                        rd_req_valid,
  input  logic                        rd_req_ready,
  output logic [BASE_W+OFF_W+1:0]     rd_req_addr,
  input  logic                        rd_rsp_valid,
  output logic                        rd_rsp_ready,
  input  logic [DW-1:0]               rd_rsp_data,
  input  logic                        rd_rsp_err,
  output logic                        restart_valid,
  input  logic                        restart_ready,
  output logic                        ld_we,
  output logic [IW-1:0]               ld_idx,
  output logic [DW-1:0]               ld_data,
  output logic                        clr_link,
  output logic                        busy,
  output logic                        done_o,
  output logic                        err_o
);
  localparam int unsigned AW = BASE_W + OFF_W + 2;

  ld_state_e         state_q;
  logic [NREG-1:0]   pend_q;
  logic [AW-1:0]     addr_q;
  logic              keep_link_q;
  logic [IW-1:0]     nxt_idx;

  // lowest pending slot is fetched first
  always_comb begin
    nxt_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pend_q[i]) nxt_idx = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LD_IDLE;
      pend_q      <= '0;
      addr_q      <= '0;
      keep_link_q <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        LD_IDLE: begin
          if (blk_done) begin
            if (link_word == '0) begin
              done_o <= 1'b1;
            end else begin
              pend_q      <= link_word[LINK_FLAG_LSB +: NREG];
              keep_link_q <= link_word[LINK_FLAG_LSB + NREG - 1];
              addr_q      <= {base, link_word[LINK_OFF_LSB +: OFF_W], 2'b00};
              state_q     <= LD_REQ;
            end
          end
        end
        LD_REQ: begin
          if (pend_q == '0) begin
            state_q <= LD_RESTART;
          end else if (rd_req_ready) begin
            state_q <= LD_WAIT;
          end
        end
        LD_WAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              err_o   <= 1'b1;
              pend_q  <= '0;
              state_q <= LD_IDLE;
            end else begin
              pend_q[nxt_idx] <= 1'b0;
              addr_q          <= addr_q + AW'(4);
              state_q         <= LD_REQ;
            end
          end
        end
        LD_RESTART: begin
          if (restart_ready) state_q <= LD_IDLE;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign rd_req_valid  = (state_q == LD_REQ) && (pend_q != '0);
  assign rd_req_addr   = addr_q;
  assign rd_rsp_ready  = (state_q == LD_WAIT);
  assign restart_valid = (state_q == LD_RESTART);
  assign busy          = (state_q != LD_IDLE);
  assign clr_link      = (state_q == LD_REQ) && (pend_q == '0) && !keep_link_q;
  assign ld_we         = (state_q == LD_WAIT) && rd_rsp_valid && !rd_rsp_err;
  assign ld_idx        = nxt_idx;
  assign ld_data       = rd_rsp_data;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R7
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);
  // R9
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_valid && !restart_ready) |=> restart_valid);
  // R3
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy && !rd_req_valid));
  // R8
  error_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy && !restart_valid));
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> (rd_req_addr == $past(rd_req_addr) + AW'(4)));
endmodule

// File: rtl/dma_ll_xfer_count.sv
module dma_ll_xfer_count
  import dma_ll_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]      tr1,
  input  logic [DW-1:0]      blk,
  output logic [BYTES_W-1:0] xfers
);
  logic [1:0] code;
  logic [1:0] shift;

  assign code  = tr1[DW_CODE_LSB +: 2];
  assign shift = (code == 2'd3) ? 2'd2 : code;
  assign xfers = blk[BYTES_W-1:0] >> shift;
endmodule

// File: rtl/dma_ll_loader.sv
module dma_ll_loader
  import dma_ll_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned BASE_W = 16,
  parameter int unsigned OFF_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_we,
  input  logic [2:0]              sw_sel,
  input  logic [DW-1:0]           sw_wdata,
  input  logic                    blk_done,
  output logic                    restart_valid,
  input  logic                    restart_ready,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [BASE_W+OFF_W+1:0] rd_req_addr,
  input  logic                    rd_rsp_valid,
  output logic                    rd_rsp_ready,
  input  logic [DW-1:0]           rd_rsp_data,
  input  logic                    rd_rsp_err,
  output logic [DW-1:0]           ch_tr1,
  output logic [DW-1:0]           ch_tr2,
  output logic [DW-1:0]           ch_blk,
  output logic [DW-1:0]           ch_src,
  output logic [DW-1:0]           ch_dst,
  output logic [DW-1:0]           ch_link,
  output logic [BYTES_W-1:0]      blk_xfers,
  output logic                    busy,
  output logic                    done,
  output logic                    error
);
  localparam int unsigned NREG = 6;
  localparam int unsigned IW   = 3;
  localparam logic [IW-1:0] BASE_SEL = IW'(NREG);

  logic [NREG-1:0][DW-1:0] regs;
  logic [BASE_W-1:0]       base_q;
  logic                    sw_ok;
  logic                    ld_we;
  logic [IW-1:0]           ld_idx;
  logic [DW-1:0]           ld_data;
  logic                    clr_link;

  assign sw_ok = sw_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          base_q <= '0;
    else if (sw_ok && sw_sel == BASE_SEL) base_q <= sw_wdata[BASE_W-1:0];
  end

  dma_ll_regfile #(.NREG(NREG), .DW(DW), .IW(IW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sw_ok),
    .sw_idx   (sw_sel),
    .sw_data  (sw_wdata),
    .ld_we    (ld_we),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data),
    .clr_link (clr_link),
    .regs_o   (regs)
  );

  dma_ll_seq #(.NREG(NREG), .DW(DW), .BASE_W(BASE_W), .OFF_W(OFF_W), .IW(IW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .blk_done      (blk_done),
    .link_word     (regs[SLOT_LINK]),
    .base          (base_q),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_ready  (rd_rsp_ready),
    .rd_rsp_data   (rd_rsp_data),
    .rd_rsp_err    (rd_rsp_err),
    .restart_valid (restart_valid),
    .restart_ready (restart_ready),
    .ld_we         (ld_we),
    .ld_idx        (ld_idx),
    .ld_data       (ld_data),
    .clr_link      (clr_link),
    .busy          (busy),
    .done_o        (done),
    .err_o         (error)
  );

  dma_ll_xfer_count #(.DW(DW)) u_xfer (
    .tr1   (regs[SLOT_TR1]),
    .blk   (regs[SLOT_BLK]),
    .xfers (blk_xfers)
  );

  assign ch_tr1  = regs[SLOT_TR1];
  assign ch_tr2  = regs[SLOT_TR2];
  assign ch_blk  = regs[SLOT_BLK];
  assign ch_src  = regs[SLOT_SRC];
  assign ch_dst  = regs[SLOT_DST];
  assign ch_link = regs[SLOT_LINK];

  // R2
  base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q));
endmodule

// File: tb/test_dma_ll_loader.sv
module test_dma_ll_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic        blk_done = 1'b0;
  logic        restart_valid, restart_ready = 1'b0;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic [31:0] ch_tr1, ch_tr2, ch_blk, ch_src, ch_dst, ch_link;
  logic [15:0] blk_xfers;
  logic        busy, done, error;

  always #4 clk = ~clk;  // 125 MHz

  dma_ll_loader i_dma_ll_loader (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .blk_done(blk_done), .restart_valid(restart_valid), .restart_ready(restart_ready),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .ch_tr1(ch_tr1), .ch_tr2(ch_tr2), .ch_blk(ch_blk),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link), .blk_xfers(blk_xfers),
    .busy(busy), .done(done), .error(error)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] err_addr = 32'hFFFF_FFFC;
  int gap = 0;

  // reference model state
  int          m_st = 0;   // 0 idle, 1 request, 2 await data, 3 restart
  logic [31:0] m_regs [6];
  logic [15:0] m_base;
  int          m_q [$];
  logic [31:0] m_addr;
  logic        m_keep;
  logic        m_done, m_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_xfers(input logic [31:0] t1, input logic [31:0] b);
    int bytes;
    case (t1[17:16])
      2'd0: bytes = 1;
      2'd1: bytes = 2;
      default: bytes = 4;
    endcase
    return 16'(int'(b[15:0]) / bytes);
  endfunction

  // model advances on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_base = '0; m_addr = '0; m_keep = 0; m_done = 0; m_err = 0;
      m_q.delete();
      for (int i = 0; i < 6; i++) m_regs[i] = '0;
    end else begin
      m_done = 0; m_err = 0;
      case (m_st)
        0: begin
          if (sw_we) begin
            if (sw_sel < 3'd6) m_regs[sw_sel] = sw_wdata;
            else if (sw_sel == 3'd6) m_base = sw_wdata[15:0];
          end
          if (blk_done) begin
            if (m_regs[5] == 32'h0) m_done = 1;
            else begin
              m_q.delete();
              for (int i = 0; i < 6; i++) if (m_regs[5][16+i]) m_q.push_back(i);
              m_keep = m_regs[5][21];
              m_addr = {m_base, m_regs[5][15:2], 2'b00};
              m_st = 1;
            end
          end
        end
        1: begin
          if (m_q.size() == 0) begin
            if (!m_keep) m_regs[5] = '0;
            m_st = 3;
          end else if (rd_req_ready) m_st = 2;
        end
        2: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin m_err = 1; m_st = 0; end
            else begin
              m_regs[m_q[0]] = rd_rsp_data;
              void'(m_q.pop_front());
              m_addr = m_addr + 32'd4;
              m_st = 1;
            end
          end
        end
        default: if (restart_ready) m_st = 0;
      endcase
    end
  end

  // compare every cycle, then drive memory and mover readiness
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(ch_tr1 == m_regs[0], "R5", "tr1", ch_tr1, m_regs[0]);
      chk(ch_tr2 == m_regs[1], "R5", "tr2", ch_tr2, m_regs[1]);
      chk(ch_blk == m_regs[2], "R5", "blk", ch_blk, m_regs[2]);
      chk(ch_src == m_regs[3], "R5", "src", ch_src, m_regs[3]);
      chk(ch_dst == m_regs[4], "R5", "dst", ch_dst, m_regs[4]);
      chk(ch_link == m_regs[5], "R6", "link", ch_link, m_regs[5]);
      chk(rd_req_valid == (m_st == 1 && m_q.size() > 0), "R7", "req_valid",
          32'(rd_req_valid), 32'(m_st == 1 && m_q.size() > 0));
      if (m_st == 1 || m_st == 2)
        chk(rd_req_addr == m_addr, "R4", "req_addr", rd_req_addr, m_addr);
      chk(rd_rsp_ready == (m_st == 2), "R7", "rsp_ready", 32'(rd_rsp_ready), 32'(m_st == 2));
      chk(restart_valid == (m_st == 3), "R9", "restart_valid", 32'(restart_valid), 32'(m_st == 3));
      chk(busy == (m_st != 0), "R9", "busy", 32'(busy), 32'(m_st != 0));
      chk(done == m_done, "R3", "done", 32'(done), 32'(m_done));
      chk(error == m_err, "R8", "error", 32'(error), 32'(m_err));
      chk(blk_xfers == exp_xfers(m_regs[0], m_regs[2]), "R10", "xfers",
          32'(blk_xfers), 32'(exp_xfers(m_regs[0], m_regs[2])));
    end
    rd_req_ready  = (cyc % 3) != 1;
    restart_ready = (cyc % 4) == 0;
    if (rd_rsp_valid) begin
      rd_rsp_valid = 0; rd_rsp_err = 0;
    end else if (rd_rsp_ready) begin
      if (gap == 0) begin
        rd_rsp_valid = 1;
        rd_rsp_data  = mem.exists(rd_req_addr) ? mem[rd_req_addr] : 32'h0;
        rd_rsp_err   = (rd_req_addr == err_addr);
        gap = cyc % 2;
      end else gap--;
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_sel = sel; sw_wdata = d;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic kick;
    @(negedge clk); blk_done = 1;
    @(negedge clk); blk_done = 0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    // descriptors
    mem[32'h2000_0100] = 32'h0002_0000; mem[32'h2000_0104] = 32'h0000_0011;
    mem[32'h2000_0108] = 32'h0000_0040; mem[32'h2000_010C] = 32'h1111_0000;
    mem[32'h2000_0110] = 32'h2222_0000;
    mem[32'h2000_0114] = (32'h1 << 18) | (32'h1 << 20) | 32'h0000_0200;
    mem[32'h2000_0200] = 32'h0000_0031; mem[32'h2000_0204] = 32'h3333_0000;
    mem[32'h2000_0300] = 32'h0001_0000; mem[32'h2000_0304] = 32'h5555_5555;
    mem[32'h4000_C400] = 32'h0001_0000; mem[32'h4000_C404] = 32'h0000_0005;
    mem[32'h4000_C408] = 32'h0000_0100; mem[32'h4000_C40C] = 32'hD000_0000;
    mem[32'h4000_C410] = 32'hD100_0000; mem[32'h4000_C414] = 32'h003F_C500;
    mem[32'h4000_C500] = 32'h0000_0000; mem[32'h4000_C504] = 32'h0000_0006;
    mem[32'h4000_C508] = 32'h0000_0007; mem[32'h4000_C50C] = 32'hE000_0000;
    mem[32'h4000_C510] = 32'hE100_0000; mem[32'h4000_C514] = 32'h003F_C400;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ch_tr1 == 0 && ch_tr2 == 0 && ch_blk == 0 && ch_src == 0 && ch_dst == 0 && ch_link == 0,
        "R1", "regs zero", ch_link, 32'h0);
    chk(!busy && !done && !error && !rd_req_valid && !rd_rsp_ready && !restart_valid,
        "R1", "flags low", {26'h0, busy, done, error, rd_req_valid, rd_rsp_ready, restart_valid}, 32'h0);

    // R2 software load, R3 end of list with zero link
    sw_write(3'd0, 32'h0003_0000);
    sw_write(3'd2, 32'h0000_0013);
    sw_write(3'd3, 32'hAAAA_0000);
    chk(ch_src == 32'hAAAA_0000, "R2", "sw write src", ch_src, 32'hAAAA_0000);
    chk(blk_xfers == 16'd4, "R10", "width code 3", 32'(blk_xfers), 32'd4);
    kick();
    chk(done == 1'b1 && !busy, "R3", "done pulse", 32'(done), 32'h1);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done one cycle", 32'(done), 32'h0);

    // R4 R5 full load, then partial load with link flag clear (R6)
    sw_write(3'd6, 32'h0000_2000);
    sw_write(3'd5, 32'h003F_0100);
    kick();
    // R2 write while busy must be ignored
    sw_write(3'd3, 32'hDEAD_BEEF);
    wait_idle();
    chk(ch_src == 32'h1111_0000, "R2", "busy write ignored", ch_src, 32'h1111_0000);
    chk(blk_xfers == 16'd16, "R10", "word width count", 32'(blk_xfers), 32'd16);
    kick();
    wait_idle();
    chk(ch_tr1 == 32'h0002_0000, "R5", "unflagged tr1 kept", ch_tr1, 32'h0002_0000);
    chk(ch_blk == 32'h0000_0031, "R5", "flagged blk loaded", ch_blk, 32'h31);
    chk(ch_dst == 32'h3333_0000, "R5", "flagged dst loaded", ch_dst, 32'h3333_0000);
    chk(ch_link == 32'h0, "R6", "link cleared", ch_link, 32'h0);
    kick();
    chk(done == 1'b1, "R3", "list end", 32'(done), 32'h1);

    // R8 error on the second word
    err_addr = 32'h2000_0304;
    sw_write(3'd5, 32'h0027_0300);
    kick();
    wait_idle();
    chk(ch_tr1 == 32'h0001_0000, "R8", "first word kept", ch_tr1, 32'h0001_0000);
    chk(ch_tr2 == 32'h0000_0011, "R8", "tr2 untouched", ch_tr2, 32'h11);
    chk(ch_link == 32'h0027_0300, "R8", "link untouched", ch_link, 32'h0027_0300);
    err_addr = 32'hFFFF_FFFC;

    // R11 circular list in another window
    sw_write(3'd6, 32'h0000_4000);
    sw_write(3'd5, 32'h003F_C400);
    for (int lap = 0; lap < 3; lap++) begin
      kick(); wait_idle();
      chk(ch_src == 32'hD000_0000, "R11", "first item", ch_src, 32'hD000_0000);
      chk(blk_xfers == 16'h0080, "R10", "half width count", 32'(blk_xfers), 32'h80);
      kick(); wait_idle();
      chk(ch_src == 32'hE000_0000, "R11", "second item", ch_src, 32'hE000_0000);
      chk(ch_link == 32'h003F_C400, "R11", "links back", ch_link, 32'h003F_C400);
    end
    sw_write(3'd5, 32'h0);
    kick();
    chk(done == 1'b1, "R3", "circular stopped", 32'(done), 32'h1);
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule